// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This controller collects service requests from five sources that sit beside a small processor core: two active-low external pins, two timer overflow pulses and a serial-port event pulse. Each request is held in a flag. Software reaches a register write port that holds an enable mask with a global gate, a two-level priority selection, the flags themselves and a trigger mode for each external pin. Whole-byte writes and single-bit writes are both supported.

At every instruction boundary the core reports, the controller picks the best eligible request. It raises a request strobe together with a vector address and holds both until the core accepts. Acceptance marks the chosen priority level as in service. A high-level request may interrupt low-level service. A return pulse ends the most urgent active service. Recognition is suppressed for one boundary after a return or after a change to the enable or priority setting.

Top module: `vic2_ctrl`

## Requirements
- R1: After reset, the request strobe is low, the vector reads 0x00, all flags are clear and no level is in service.
- R2: Register select 0 holds the enables, with source bits 0..4 (external 0, timer 0, external 1, timer 1, serial) and global gate bit 7. Select 1 holds the priority bits at the same positions. Select 2 holds flag bits 0..4. Select 3 holds the trigger bits, bit 0 for external 0 and bit 1 for external 1. With the bit-write input high, only the bit named by the bit index is replaced, by data bit 0.
- R3: While the global gate bit is 0, no request is raised. Flags that are already set stay set.
- R4: A source whose enable bit is 0 is not taken. Its flag stays pending and is taken once the source is enabled.
- R5: A high-level request (priority bit 1) wins over any low-level one. Within one level, the order from first to last is external 0, timer 0, external 1, timer 1, serial.
- R6: The vector for source index i (the bit position in R2) is 8*i+3: 0x03, 0x0B, 0x13, 0x1B or 0x23.
- R7: With trigger bit 1, a high-to-low transition on the external pin sets its flag, and a pin held low does not set it again. With trigger bit 0, the flag follows the inverted pin level.
- R8: A flag set through the write port gives the same request and vector as one set by a hardware event.
- R9: On acceptance, the flag of a timer source or of an edge-mode external source is cleared. A level-mode external flag and the serial flag are left unchanged.
- R10: The first boundary after a return pulse, or after a write to select 0 or 1, raises no request. A later boundary may raise one.
- R11: There is one in-service bit per level (bit 1 high, bit 0 low). High service blocks every request. Low service blocks only low-level requests.
- R12: A return pulse clears the high in-service bit if it is set, and otherwise clears the low one.
- R13: Once raised, the request strobe and vector stay unchanged until the accept input is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n_i | input | 2 | External request pins, active low |
| tmr_ovf_i | input | 2 | Timer overflow pulses |
| ser_evt_i | input | 1 | Serial event pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select |
| wr_bit_i | input | 1 | Single-bit write mode |
| wr_bsel_i | input | 3 | Bit index for single-bit writes |
| wr_data_i | input | 8 | Write data |
| boundary_i | input | 1 | Instruction boundary pulse |
| accept_i | input | 1 | Core accepts the pending request |
| reti_i | input | 1 | Return-from-service pulse |
| irq_req_o | output | 1 | Request strobe to the core |
| irq_vec_o | output | 8 | Vector address |
| flags_o | output | 5 | Current request flags |
| isr_o | output | 2 | In-service bits (bit 1 high, bit 0 low) |

## Verification
The assertions assume the core behaves as a well-formed partner. The accept input is pulsed only while the strobe is high. A return pulse comes only while some level is in service, and never in the same cycle as an accept or a boundary. The bench keeps to these rules: every accept follows a boundary whose scoreboard item expected a request, and every return follows an accept. Inputs change only on falling clock edges, and each handshake pulse lasts one cycle.

// File: rtl/vic2_pkg.sv
package vic2_pkg;
  localparam int NSRC = 5;
  localparam int IW   = $clog2(NSRC);
  localparam int DW   = 8;
  localparam int GATE_BIT = 7;

  typedef enum logic [1:0] {
    SEL_EN  = 2'd0,
    SEL_PRI = 2'd1,
    SEL_FLG = 2'd2,
    SEL_TRG = 2'd3
  } reg_sel_e;

  function automatic logic [DW-1:0] vec_of(input logic [IW-1:0] idx,
                                           input int ofs, input int stride);
    int v;
    v = ofs + stride * int'(idx);
    return DW'(v);
  endfunction

  function automatic logic [IW-1:0] first_set(input logic [NSRC-1:0] m);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (m[i]) r = IW'(i);
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] merge_wr(input logic [DW-1:0] old,
                                             input logic [DW-1:0] data,
                                             input logic bitmode,
                                             input logic [2:0] bsel);
    logic [DW-1:0] r;
    r = data;
    if (bitmode) begin
      r = old;
      r[bsel] = data[0];
    end
    return r;
  endfunction
endpackage

// File: rtl/vic2_flags.sv
module vic2_flags
  import vic2_pkg::*;
#(
  parameter int NEXT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEXT-1:0] ext_n_i,
  input  logic [NEXT-1:0] trig_i,
  input  logic [NEXT-1:0] tmr_set_i,
  input  logic            ser_set_i,
  input  logic [NSRC-1:0] sw_mask_i,
  input  logic [NSRC-1:0] sw_val_i,
  input  logic [NSRC-1:0] svc_clr_i,
  output logic [NSRC-1:0] flags_o,
  output logic [NEXT-1:0] ext_fall_o
);
  logic [NEXT-1:0] pin_prev_q;
  logic [NSRC-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev_q <= '1;
    else        pin_prev_q <= ext_n_i;
  end

  assign ext_fall_o = pin_prev_q & ~ext_n_i;

  for (genvar k = 0; k < NEXT; k++) begin : g_pair
    localparam int XI = 2 * k;
    localparam int TI = 2 * k + 1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[XI] <= 1'b0;
      end else if (!trig_i[k]) begin
        flag_q[XI] <= ~ext_n_i[k];
      end else if (ext_fall_o[k]) begin
        flag_q[XI] <= 1'b1;
      end else if (sw_mask_i[XI]) begin
        flag_q[XI] <= sw_val_i[XI];
      end else if (svc_clr_i[XI]) begin
        flag_q[XI] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[TI] <= 1'b0;
      end else if (tmr_set_i[k]) begin
        flag_q[TI] <= 1'b1;
      end else if (sw_mask_i[TI]) begin
        flag_q[TI] <= sw_val_i[TI];
      end else if (svc_clr_i[TI]) begin
        flag_q[TI] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q[NSRC-1] <= 1'b0;
    end else if (ser_set_i) begin
      flag_q[NSRC-1] <= 1'b1;
    end else if (sw_mask_i[NSRC-1]) begin
      flag_q[NSRC-1] <= sw_val_i[NSRC-1];
    end
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/vic2_arb.sv
module vic2_arb
  import vic2_pkg::*;
#(
  parameter int VEC_OFS    = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic [NSRC-1:0] flags_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            gate_i,
  input  logic [NSRC-1:0] pri_i,
  input  logic [1:0]      isr_i,
  output logic            win_o,
  output logic            win_hi_o,
  output logic [IW-1:0]   win_idx_o,
  output logic [DW-1:0]   win_vec_o
);
  logic [NSRC-1:0] elig_w, hi_w, lo_w;

  assign elig_w = flags_i & en_i & {NSRC{gate_i}};
  assign hi_w   = elig_w & pri_i;
  assign lo_w   = elig_w & ~pri_i;

  always_comb begin
    win_o     = 1'b0;
    win_hi_o  = 1'b0;
    win_idx_o = '0;
    if ((|hi_w) && !isr_i[1]) begin
      win_o     = 1'b1;
      win_hi_o  = 1'b1;
      win_idx_o = first_set(hi_w);
    end else if ((|lo_w) && (isr_i == 2'b00)) begin
      win_o     = 1'b1;
      win_idx_o = first_set(lo_w);
    end
  end

  assign win_vec_o = vec_of(win_idx_o, VEC_OFS, VEC_STRIDE);
endmodule

// File: rtl/vic2_svc.sv
module vic2_svc
  import vic2_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            boundary_i,
  input  logic            accept_i,
  input  logic            reti_i,
  input  logic            cfg_wr_i,
  input  logic            win_i,
  input  logic            win_hi_i,
  input  logic [IW-1:0]   win_idx_i,
  input  logic [DW-1:0]   win_vec_i,
  output logic            req_o,
  output logic [DW-1:0]   vec_o,
  output logic [1:0]      isr_o,
  output logic            blk_o,
  output logic [NSRC-1:0] svc_clr_o
);
  logic            req_q, hi_q, blk_q;
  logic [IW-1:0]   idx_q;
  logic [DW-1:0]   vec_q;
  logic [1:0]      isr_q;
  logic            rec_w, take_w;

  assign rec_w  = boundary_i && !blk_q && win_i && !req_q;
  assign take_w = accept_i && req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   blk_q <= 1'b0;
    else if (cfg_wr_i || reti_i)  blk_q <= 1'b1;
    else if (boundary_i)          blk_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      hi_q  <= 1'b0;
      idx_q <= '0;
      vec_q <= '0;
    end else if (rec_w) begin
      req_q <= 1'b1;
      hi_q  <= win_hi_i;
      idx_q <= win_idx_i;
      vec_q <= win_vec_i;
    end else if (take_w) begin
      req_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= 2'b00;
    end else if (take_w) begin
      if (hi_q) isr_q[1] <= 1'b1;
      else      isr_q[0] <= 1'b1;
    end else if (reti_i) begin
      if (isr_q[1]) isr_q[1] <= 1'b0;
      else          isr_q[0] <= 1'b0;
    end
  end

  always_comb begin
    svc_clr_o = '0;
    if (take_w) svc_clr_o[idx_q] = 1'b1;
  end

  assign req_o = req_q;
  assign vec_o = vec_q;
  assign isr_o = isr_q;
  assign blk_o = blk_q;
endmodule

// File: rtl/vic2_ctrl.sv
module vic2_ctrl
  import vic2_pkg::*;
#(
  parameter int NEXT       = 2,
  parameter int VEC_OFS    = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      ext_n_i,
  input  logic [1:0]      tmr_ovf_i,
  input  logic            ser_evt_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_sel_i,
  input  logic            wr_bit_i,
  input  logic [2:0]      wr_bsel_i,
  input  logic [7:0]      wr_data_i,
  input  logic            boundary_i,
  input  logic            accept_i,
  input  logic            reti_i,
  output logic            irq_req_o,
  output logic [7:0]      irq_vec_o,
  output logic [4:0]      flags_o,
  output logic [1:0]      isr_o
);
  localparam logic [DW-1:0] EN_KEEP  = DW'((1 << GATE_BIT) | ((1 << NSRC) - 1));
  localparam logic [DW-1:0] PRI_KEEP = DW'((1 << NSRC) - 1);

  logic [DW-1:0]   en_q, pri_q, wr_word_w, flg_word_w;
  logic [NEXT-1:0] trg_q;
  logic [NSRC-1:0] sw_mask_w, sw_val_w, svc_clr_w, flags_w;
  logic [NEXT-1:0] ext_fall_w;
  logic            cfg_wr_w, blk_w, gie_w;
  logic            win_w, win_hi_w;
  logic [IW-1:0]   win_idx_w;
  logic [DW-1:0]   win_vec_w;

  assign cfg_wr_w = wr_en_i && (wr_sel_i == SEL_EN || wr_sel_i == SEL_PRI);

  always_comb begin
    case (reg_sel_e'(wr_sel_i))
      SEL_EN:  wr_word_w = merge_wr(en_q, wr_data_i, wr_bit_i, wr_bsel_i);
      SEL_PRI: wr_word_w = merge_wr(pri_q, wr_data_i, wr_bit_i, wr_bsel_i);
      SEL_FLG: wr_word_w = merge_wr(DW'(flags_w), wr_data_i, wr_bit_i, wr_bsel_i);
      default: wr_word_w = merge_wr(DW'(trg_q), wr_data_i, wr_bit_i, wr_bsel_i);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pri_q <= '0;
      trg_q <= '0;
    end else if (wr_en_i) begin
      case (reg_sel_e'(wr_sel_i))
        SEL_EN:  en_q  <= wr_word_w & EN_KEEP;
        SEL_PRI: pri_q <= wr_word_w & PRI_KEEP;
        SEL_TRG: trg_q <= wr_word_w[NEXT-1:0];
        default: ;
      endcase
    end
  end

  assign flg_word_w = wr_word_w;
  assign sw_mask_w  = (wr_en_i && wr_sel_i == SEL_FLG) ?
                      (wr_bit_i ? NSRC'(1 << wr_bsel_i) : '1) : '0;
  assign sw_val_w   = flg_word_w[NSRC-1:0];
  assign gie_w      = en_q[GATE_BIT];

  vic2_flags #(.NEXT(NEXT)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_n_i    (ext_n_i),
    .trig_i     (trg_q),
    .tmr_set_i  (tmr_ovf_i),
    .ser_set_i  (ser_evt_i),
    .sw_mask_i  (sw_mask_w),
    .sw_val_i   (sw_val_w),
    .svc_clr_i  (svc_clr_w),
    .flags_o    (flags_w),
    .ext_fall_o (ext_fall_w)
  );

  vic2_arb #(.VEC_OFS(VEC_OFS), .VEC_STRIDE(VEC_STRIDE)) u_arb (
    .flags_i   (flags_w),
    .en_i      (en_q[NSRC-1:0]),
    .gate_i    (gie_w),
    .pri_i     (pri_q[NSRC-1:0]),
    .isr_i     (isr_o),
    .win_o     (win_w),
    .win_hi_o  (win_hi_w),
    .win_idx_o (win_idx_w),
    .win_vec_o (win_vec_w)
  );

  vic2_svc u_svc (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary_i (boundary_i),
    .accept_i   (accept_i),
    .reti_i     (reti_i),
    .cfg_wr_i   (cfg_wr_w),
    .win_i      (win_w),
    .win_hi_i   (win_hi_w),
    .win_idx_i  (win_idx_w),
    .win_vec_i  (win_vec_w),
    .req_o      (irq_req_o),
    .vec_o      (irq_vec_o),
    .isr_o      (isr_o),
    .blk_o      (blk_w),
    .svc_clr_o  (svc_clr_w)
  );

  assign flags_o = flags_w;
endmodule

// File: rtl/vic2_chk.sv
module vic2_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       boundary_i,
  input logic       accept_i,
  input logic       reti_i,
  input logic       req,
  input logic [7:0] vec,
  input logic [1:0] isr,
  input logic       blk,
  input logic       gie
);
  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !accept_i) |=> (req && $stable(vec)));

  assert_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> ($past(boundary_i) && !$past(blk)));

  assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (vec == 8'h03 || vec == 8'h0B || vec == 8'h13 ||
             vec == 8'h1B || vec == 8'h23));

  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(gie));

  assert_nest_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> !$past(isr[1]));

  assert_enter_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && req) |=> (isr != 2'b00));

  assert_reti_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && isr == 2'b11) |=> (isr == 2'b01));
endmodule

bind vic2_ctrl vic2_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .boundary_i (boundary_i),
  .accept_i   (accept_i),
  .reti_i     (reti_i),
  .req        (irq_req_o),
  .vec        (irq_vec_o),
  .isr        (isr_o),
  .blk        (blk_w),
  .gie        (gie_w)
);

// File: tb/tb_vic2_ctrl.sv
module tb_vic2_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext_n_i = 2'b11;
  logic [1:0] tmr_ovf_i = 2'b00;
  logic       ser_evt_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd0;
  logic       wr_bit_i = 1'b0;
  logic [2:0] wr_bsel_i = 3'd0;
  logic [7:0] wr_data_i = 8'h00;
  logic       boundary_i = 1'b0;
  logic       accept_i = 1'b0;
  logic       reti_i = 1'b0;
  logic       irq_req_o;
  logic [7:0] irq_vec_o;
  logic [4:0] flags_o;
  logic [1:0] isr_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    bit         req;
    logic [7:0] vec;
    string      rid;
  } sb_item_t;
  sb_item_t sbq[$];

  always #5 clk = ~clk;

  vic2_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_n_i(ext_n_i), .tmr_ovf_i(tmr_ovf_i),
    .ser_evt_i(ser_evt_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_bit_i(wr_bit_i), .wr_bsel_i(wr_bsel_i), .wr_data_i(wr_data_i),
    .boundary_i(boundary_i), .accept_i(accept_i), .reti_i(reti_i),
    .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o), .flags_o(flags_o),
    .isr_o(isr_o)
  );

  function automatic logic [7:0] exp_vec(input int src);
    return 8'(src * 8 + 3);
  endfunction

  // monitor: compares queued expectations on the falling edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      n_tests++;
      if (irq_req_o !== it.req || (it.req && irq_vec_o !== it.vec)) begin
        n_fail++;
        $display("FAIL %s: req=%0b vec=%02h expected req=%0b vec=%02h",
                 it.rid, irq_req_o, irq_vec_o, it.req, it.vec);
      end
    end
  end

  task automatic check(input string rid, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", rid, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_bit_i = 1'b0; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic wr_bit(input logic [1:0] sel, input int b, input logic v);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_bit_i = 1'b1;
    wr_bsel_i = 3'(b); wr_data_i = {7'd0, v};
    tick();
    wr_en_i = 1'b0; wr_bit_i = 1'b0;
  endtask

  // driver: one boundary pulse, expected outcome pushed to the scoreboard
  task automatic bnd(input bit req, input int src, input string rid);
    sb_item_t it;
    @(negedge clk);
    boundary_i = 1'b1;
    tick();
    boundary_i = 1'b0;
    it.req = req; it.vec = req ? exp_vec(src) : 8'h00; it.rid = rid;
    sbq.push_back(it);
  endtask

  task automatic acc();
    @(negedge clk);
    accept_i = 1'b1;
    tick();
    accept_i = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk);
    reti_i = 1'b1;
    tick();
    reti_i = 1'b0;
  endtask

  task automatic tmr(input int k);
    @(negedge clk);
    tmr_ovf_i[k] = 1'b1;
    tick();
    tmr_ovf_i = 2'b00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    check("R1 req", {7'd0, irq_req_o}, 8'h00);
    check("R1 vec", irq_vec_o, 8'h00);
    check("R1 flags", {3'd0, flags_o}, 8'h00);
    check("R1 isr", {6'd0, isr_o}, 8'h00);

    // R2 edge trigger on both pins, sources enabled with gate off
    wr(2'd3, 8'h03);
    wr(2'd0, 8'h1F);
    tmr(0);
    settle();
    check("R2 timer0 flag set", {3'd0, flags_o}, 8'h02);
    bnd(1'b0, 0, "R10 blocked after enable write");
    bnd(1'b0, 0, "R3 gate off");
    settle();
    check("R3 flag still pending", {3'd0, flags_o}, 8'h02);

    // R2 bit write of the gate bit, then R10 block, then timer 0 taken
    wr_bit(2'd0, 7, 1'b1);
    bnd(1'b0, 0, "R10 blocked after bit write");
    bnd(1'b1, 1, "R6 timer0 vector");
    acc();
    settle();
    check("R9 timer0 flag cleared", {3'd0, flags_o}, 8'h00);
    check("R11 low in service", {6'd0, isr_o}, 8'h01);

    // R11 low-level request cannot preempt low service
    tmr(1);
    bnd(1'b0, 0, "R11 no preempt at same level");
    ret();
    settle();
    check("R12 low cleared", {6'd0, isr_o}, 8'h00);
    bnd(1'b0, 0, "R10 blocked after return");
    bnd(1'b1, 3, "R4 timer1 taken when eligible");
    acc(); ret(); bnd(1'b0, 0, "R10 blocked after return 2");

    // R8 software set all flags; serial placed in high level
    wr(2'd2, 8'h1F);
    settle();
    check("R8 flags written", {3'd0, flags_o}, 8'h1F);
    wr(2'd1, 8'h10);
    bnd(1'b0, 0, "R10 blocked after priority write");
    bnd(1'b1, 4, "R5 high serial beats low ext0");
    acc();
    settle();
    check("R9 serial flag kept", {3'd0, flags_o}, 8'h1F);
    check("R11 high in service", {6'd0, isr_o}, 8'h02);
    bnd(1'b0, 0, "R11 high service blocks all");
    ret(); bnd(1'b0, 0, "R10 blocked after return 3");
    wr_bit(2'd2, 4, 1'b0);
    settle();
    check("R2 serial flag cancelled", {3'd0, flags_o}, 8'h0F);
    bnd(1'b1, 0, "R5 ext0 first in low level");
    acc();
    settle();
    check("R9 edge ext0 flag cleared", {3'd0, flags_o}, 8'h0E);

    // R11 preemption of low service by high timer 0
    wr(2'd1, 8'h02);
    bnd(1'b0, 0, "R10 blocked after priority write 2");
    bnd(1'b1, 1, "R11 high preempts low");
    acc();
    settle();
    check("R11 both levels", {6'd0, isr_o}, 8'h03);
    ret();
    settle();
    check("R12 high cleared first", {6'd0, isr_o}, 8'h01);
    bnd(1'b0, 0, "R10 blocked after return 4");
    ret(); bnd(1'b0, 0, "R10 blocked after return 5");
    bnd(1'b1, 2, "R5 ext1 before timer1");
    acc(); ret(); bnd(1'b0, 0, "R10 blocked after return 6");
    bnd(1'b1, 3, "R5 timer1 last");
    acc(); ret(); bnd(1'b0, 0, "R10 blocked after return 7");

    // R7 edge mode: fall sets, held low does not set again
    @(negedge clk); ext_n_i[0] = 1'b0;
    tick(); settle();
    check("R7 falling edge sets", {3'd0, flags_o}, 8'h01);
    wr_bit(2'd2, 0, 1'b0);
    repeat (2) tick();
    settle();
    check("R7 held low no reset", {3'd0, flags_o}, 8'h00);
    @(negedge clk); ext_n_i[0] = 1'b1;

    // R7 level mode on ext1
    wr(2'd3, 8'h00);
    @(negedge clk); ext_n_i[1] = 1'b0;
    tick(); settle();
    check("R7 level follows pin", {3'd0, flags_o}, 8'h04);
    bnd(1'b1, 2, "R7 level ext1 request");
    acc();
    settle();
    check("R9 level flag kept", {3'd0, flags_o}, 8'h04);
    @(negedge clk); ext_n_i[1] = 1'b1;
    tick(); settle();
    check("R7 level released", {3'd0, flags_o}, 8'h00);
    ret(); bnd(1'b0, 0, "R10 blocked after return 8");

    // R4 individual mask holds timer 1 pending
    wr(2'd0, 8'h97);
    tmr(1);
    bnd(1'b0, 0, "R10 blocked after enable write 2");
    bnd(1'b0, 0, "R4 masked source");
    settle();
    check("R4 flag pending", {3'd0, flags_o}, 8'h08);
    wr_bit(2'd0, 3, 1'b1);
    bnd(1'b0, 0, "R10 blocked after enable bit write");
    bnd(1'b1, 3, "R4 taken once enabled");
    // R13 strobe holds over a later boundary until accept
    bnd(1'b1, 3, "R13 held until accept");
    acc();
    settle();
    check("R13 dropped after accept", {7'd0, irq_req_o}, 8'h00);
    ret();

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule